// File: doc/BRIEF.md
# Split-Width Vector Uop Issue Scheduler

This block sits between vector decode and two identical half-width execution lanes. Operations arrive one per cycle, in program order, over a valid/ready handshake. Each operation is marked either full width (two halves) or half width. A full-width operation is cracked into two uops. The lower uop uses the low half of the operand field. The upper uop uses the high half of the operand field. A half-width operation becomes a single uop. Every issued uop carries its parent's tag and a half flag.

The scheduler is a two-state machine. In `ST_IDLE` no upper half is outstanding. In `ST_HOLD` one upper half waits in a holding register. The transitions are:
- **load**: `ST_IDLE` to `ST_HOLD`, taken when a full-width op is accepted.
- **wait**: `ST_HOLD` to `ST_HOLD`, taken when no lane can take the held half.
- **chain**: `ST_HOLD` to `ST_HOLD`, taken when the held half issues and a new full-width op is accepted in the same cycle.
- **drain**: `ST_HOLD` to `ST_IDLE`, taken when the held half issues and no full-width op is accepted.

In paired mode both lanes take uops. The held upper half of one op can therefore share a cycle with the first uop of the next op, whatever that op's width. In sequential mode only lane 0 is used. Each lane has its own stall input, and a stalled lane takes nothing. Issue is combinational from the handshake and the holding register.

Top module: `vec_crack_sched`

## Requirements
- R1: An accepted half-width op issues in its acceptance cycle as one uop with half flag 0, its own tag, and operand bits [HALF_W-1:0].
- R2: An accepted full-width op issues its lower uop in its acceptance cycle, with half flag 0 and operand bits [HALF_W-1:0]. Its upper uop issues in a later cycle, never the same one, with half flag 1, the same tag and operand bits [2*HALF_W-1:HALF_W].
- R3: In paired mode, with both lanes free and an upper half held, the held half and the first uop of a newly offered op issue in the same cycle.
- R4: In sequential mode lane 1 never issues. The two halves of a full-width op issue on lane 0 in consecutive cycles when lane 0 is not stalled, and in_ready is low in the cycle the upper half issues.
- R5: While an upper half is held, in_ready is high only if that half issues this cycle and a second usable lane remains.
- R6: When both lanes issue in one cycle, lane 0 carries the older uop, which is the held upper half.
- R7: A stalled lane issues nothing. In paired mode the uops then go to the other lane, one per cycle.
- R8: With no usable lane (lane 0 stalled and lane 1 stalled or sequential mode), in_ready is low and nothing issues.
- R9: Synchronous active-high reset drops any held upper half. Afterwards, with no stall, in_ready is high and no lane issues until an op is offered.
- R10: Over any mix of widths, modes and stalls, uops issue in program order: lane 0 before lane 1 within a cycle, and the lower half before the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 1 = paired two-lane issue, 0 = lane 0 only |
| lane_stall | input | 2 | Per-lane stall; bit k blocks lane k |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted this cycle when valid |
| in_wide | input | 1 | 1 = full-width op (cracked in two), 0 = half width |
| in_tag | input | TAG_W | Operation tag |
| in_opnd | input | 2*HALF_W | Operand field, low half then high half |
| lane0_vld | output | 1 | Lane 0 issues a uop |
| lane0_tag | output | TAG_W | Lane 0 parent tag |
| lane0_half | output | 1 | Lane 0 half flag (1 = upper half) |
| lane0_opnd | output | HALF_W | Lane 0 operand half |
| lane1_vld | output | 1 | Lane 1 issues a uop |
| lane1_tag | output | TAG_W | Lane 1 parent tag |
| lane1_half | output | 1 | Lane 1 half flag (1 = upper half) |
| lane1_opnd | output | HALF_W | Lane 1 operand half |

## Verification
Directed sequences cover these patterns:
- A lone half-width op separates R1 from the cracked path.
- A chain of full-width ops in paired mode shows whether an upper half shares a cycle with the next lower half (R3, R6).
- The same chain in sequential mode shows whether lane 1 is kept quiet and in_ready is pulled low (R4).
- Stalling lane 0 shows whether uops move to lane 1 and stay in order (R7).
- Stalling everything while a half is held exposes R8.
- A reset taken while a half is held exposes R9.

A long seeded random mix of widths, idle gaps, stalls and mode flips is then compared every cycle against a bench model of the issue rules, which catches ordering and lane-selection faults (R10).

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    localparam int NUM_LANES = 2;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } hold_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_HELD,
        SRC_NEW
    } lane_src_e;
endpackage

// File: rtl/vcs_lane_pick.sv
module vcs_lane_pick
    import vcs_pkg::*;
(
    input  logic                         dual_mode,
    input  logic [NUM_LANES-1:0]         lane_stall,
    input  logic                         held_vld,
    input  logic                         in_valid,
    output lane_src_e [NUM_LANES-1:0]    lane_src,
    output logic                         held_go,
    output logic                         in_ready
);
    logic [NUM_LANES-1:0] lane_ok;
    logic any_ok;
    logic all_ok;

    // Lanes above 0 are usable only in paired mode.
    always_comb begin
        for (int k = 0; k < NUM_LANES; k++) begin
            lane_ok[k] = !lane_stall[k] && ((k == 0) || dual_mode);
        end
    end

    assign any_ok = |lane_ok;
    assign all_ok = &lane_ok;

    // Older uop (held upper half) claims the lowest usable lane first.
    always_comb begin
        for (int k = 0; k < NUM_LANES; k++) begin
            lane_src[k] = SRC_NONE;
        end
        held_go  = held_vld && any_ok;
        in_ready = held_vld ? all_ok : any_ok;
        unique case (held_vld)
            1'b1: begin
                if (lane_ok[0]) begin
                    lane_src[0] = SRC_HELD;
                    if (lane_ok[1] && in_valid) begin
                        lane_src[1] = SRC_NEW;
                    end
                end else if (lane_ok[1]) begin
                    lane_src[1] = SRC_HELD;
                end
            end
            1'b0: begin
                if (in_valid) begin
                    if (lane_ok[0]) begin
                        lane_src[0] = SRC_NEW;
                    end else if (lane_ok[1]) begin
                        lane_src[1] = SRC_NEW;
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/vcs_upper_hold.sv
module vcs_upper_hold
    import vcs_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int HALF_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              held_go,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [HALF_W-1:0] in_opnd_hi,
    output logic              held_vld,
    output logic [TAG_W-1:0]  held_tag,
    output logic [HALF_W-1:0] held_opnd
);
    hold_state_e state_q;
    hold_state_e state_d;
    logic        capture;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load) begin
                    state_d = ST_HOLD;
                    capture = 1'b1;
                end
            end
            ST_HOLD: begin
                if (held_go && load) begin
                    state_d = ST_HOLD;
                    capture = 1'b1;
                end else if (held_go) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_tag  <= '0;
            held_opnd <= '0;
        end else if (capture) begin
            held_tag  <= in_tag;
            held_opnd <= in_opnd_hi;
        end
    end

    always_comb begin
        held_vld = (state_q == ST_HOLD);
    end

    AST_LOAD_ENTERS_HOLD: assert property (@(posedge clk) disable iff (rst)
        load |=> held_vld); // R2
    AST_BLOCKED_HALF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (held_vld && !held_go) |=> (held_vld && $stable(held_tag) && $stable(held_opnd))); // R2
    AST_RESET_DROPS_HALF: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !held_vld); // R9
endmodule

// File: rtl/vcs_issue_mux.sv
module vcs_issue_mux
    import vcs_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int HALF_W = 256
) (
    input  lane_src_e [NUM_LANES-1:0]              lane_src,
    input  logic [TAG_W-1:0]                       held_tag,
    input  logic [HALF_W-1:0]                      held_opnd,
    input  logic [TAG_W-1:0]                       new_tag,
    input  logic [HALF_W-1:0]                      new_opnd,
    output logic [NUM_LANES-1:0]                   lane_vld,
    output logic [NUM_LANES-1:0]                   lane_half,
    output logic [NUM_LANES-1:0][TAG_W-1:0]        lane_tag,
    output logic [NUM_LANES-1:0][HALF_W-1:0]       lane_opnd
);
    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        always_comb begin
            unique case (lane_src[k])
                SRC_HELD: begin
                    lane_vld[k]  = 1'b1;
                    lane_half[k] = 1'b1;
                    lane_tag[k]  = held_tag;
                    lane_opnd[k] = held_opnd;
                end
                SRC_NEW: begin
                    lane_vld[k]  = 1'b1;
                    lane_half[k] = 1'b0;
                    lane_tag[k]  = new_tag;
                    lane_opnd[k] = new_opnd;
                end
                default: begin
                    lane_vld[k]  = 1'b0;
                    lane_half[k] = 1'b0;
                    lane_tag[k]  = '0;
                    lane_opnd[k] = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/vec_crack_sched.sv
module vec_crack_sched
    import vcs_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int HALF_W = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  dual_mode,
    input  logic [1:0]            lane_stall,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic                  in_wide,
    input  logic [TAG_W-1:0]      in_tag,
    input  logic [2*HALF_W-1:0]   in_opnd,
    output logic                  lane0_vld,
    output logic [TAG_W-1:0]      lane0_tag,
    output logic                  lane0_half,
    output logic [HALF_W-1:0]     lane0_opnd,
    output logic                  lane1_vld,
    output logic [TAG_W-1:0]      lane1_tag,
    output logic                  lane1_half,
    output logic [HALF_W-1:0]     lane1_opnd
);
    localparam int OPND_W = 2 * HALF_W;

    lane_src_e [NUM_LANES-1:0]         lane_src;
    logic                              held_vld;
    logic                              held_go;
    logic [TAG_W-1:0]                  held_tag;
    logic [HALF_W-1:0]                 held_opnd;
    logic                              accept;
    logic                              load_upper;
    logic [NUM_LANES-1:0]              lane_vld;
    logic [NUM_LANES-1:0]              lane_half;
    logic [NUM_LANES-1:0][TAG_W-1:0]   lane_tag;
    logic [NUM_LANES-1:0][HALF_W-1:0]  lane_opnd;

    assign accept     = in_valid && in_ready;
    assign load_upper = accept && in_wide;

    vcs_lane_pick i_pick (
        .dual_mode  (dual_mode),
        .lane_stall (lane_stall),
        .held_vld   (held_vld),
        .in_valid   (in_valid),
        .lane_src   (lane_src),
        .held_go    (held_go),
        .in_ready   (in_ready)
    );

    vcs_upper_hold #(.TAG_W(TAG_W), .HALF_W(HALF_W)) i_hold (
        .clk        (clk),
        .rst        (rst),
        .load       (load_upper),
        .held_go    (held_go),
        .in_tag     (in_tag),
        .in_opnd_hi (in_opnd[OPND_W-1:HALF_W]),
        .held_vld   (held_vld),
        .held_tag   (held_tag),
        .held_opnd  (held_opnd)
    );

    vcs_issue_mux #(.TAG_W(TAG_W), .HALF_W(HALF_W)) i_mux (
        .lane_src   (lane_src),
        .held_tag   (held_tag),
        .held_opnd  (held_opnd),
        .new_tag    (in_tag),
        .new_opnd   (in_opnd[HALF_W-1:0]),
        .lane_vld   (lane_vld),
        .lane_half  (lane_half),
        .lane_tag   (lane_tag),
        .lane_opnd  (lane_opnd)
    );

    assign lane0_vld  = lane_vld[0];
    assign lane0_tag  = lane_tag[0];
    assign lane0_half = lane_half[0];
    assign lane0_opnd = lane_opnd[0];
    assign lane1_vld  = lane_vld[1];
    assign lane1_tag  = lane_tag[1];
    assign lane1_half = lane_half[1];
    assign lane1_opnd = lane_opnd[1];

    AST_LANE1_QUIET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !dual_mode |-> !lane1_vld); // R4
    AST_SINGLE_HALVES_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (load_upper && !dual_mode) |=> (dual_mode || lane_stall[0] ||
            (lane0_vld && lane0_half && !in_ready && lane0_tag == $past(in_tag)))); // R4
    AST_UPPER_BEFORE_NEW: assert property (@(posedge clk) disable iff (rst)
        load_upper |=> (!in_ready || (lane0_vld && lane0_half))); // R5
    AST_PAIR_OLDER_ON_LANE0: assert property (@(posedge clk) disable iff (rst)
        (lane0_vld && lane1_vld) |-> (lane0_half && !lane1_half)); // R6
    AST_STALL_LANE0_QUIET: assert property (@(posedge clk) disable iff (rst)
        lane_stall[0] |-> !lane0_vld); // R7
    AST_STALL_LANE1_QUIET: assert property (@(posedge clk) disable iff (rst)
        lane_stall[1] |-> !lane1_vld); // R7
    AST_NO_LANE_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (lane_stall[0] && (lane_stall[1] || !dual_mode)) |-> (!in_ready && !lane0_vld && !lane1_vld)); // R8
endmodule

// File: tb/test_vec_crack_sched.sv
module test_vec_crack_sched;
    localparam int TW = 6;
    localparam int HW = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dual_mode = 1'b1;
    logic [1:0]      lane_stall = 2'b00;
    logic            in_valid = 1'b0;
    logic            in_ready;
    logic            in_wide = 1'b0;
    logic [TW-1:0]   in_tag = '0;
    logic [2*HW-1:0] in_opnd = '0;
    logic            lane0_vld, lane0_half, lane1_vld, lane1_half;
    logic [TW-1:0]   lane0_tag, lane1_tag;
    logic [HW-1:0]   lane0_opnd, lane1_opnd;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    bit            pend = 0;
    logic [TW-1:0] pend_tag = '0;
    logic [HW-1:0] pend_opnd = '0;

    always #10 clk = ~clk;

    vec_crack_sched #(.TAG_W(TW), .HALF_W(HW)) i_vec_crack_sched (
        .clk(clk), .rst(rst), .dual_mode(dual_mode), .lane_stall(lane_stall),
        .in_valid(in_valid), .in_ready(in_ready), .in_wide(in_wide),
        .in_tag(in_tag), .in_opnd(in_opnd),
        .lane0_vld(lane0_vld), .lane0_tag(lane0_tag), .lane0_half(lane0_half), .lane0_opnd(lane0_opnd),
        .lane1_vld(lane1_vld), .lane1_tag(lane1_tag), .lane1_half(lane1_half), .lane1_opnd(lane1_opnd)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string lane_req(input int ln, input logic [1:0] ev, input logic [23:0] e,
                                       input logic [1:0] st, input bit dm, input string ctx);
        if (ctx != "") return ctx;
        if (st[ln]) return "R7";
        if (ln == 1 && !dm) return "R4";
        if (ev == 2'b11) return (ln == 0) ? "R6" : "R3";
        if (e[HW]) return "R2";
        return "R1";
    endfunction

    // One cycle: drive after negedge, compare before posedge, advance model.
    task automatic step(input bit v, input bit w, input logic [TW-1:0] t, input logic [2*HW-1:0] d,
                        input logic [1:0] st, input bit dm, input string ctx);
        bit          ok [2];
        bit          exp_rdy, acc, pend_go;
        int          ln;
        logic [1:0]  ev;
        logic [23:0] el [2];
        logic [23:0] al [2];
        string       rq;
        in_valid = v; in_wide = w; in_tag = t; in_opnd = d; lane_stall = st; dual_mode = dm;
        #1;
        ok[0] = !st[0];
        ok[1] = dm && !st[1];
        exp_rdy = pend ? (ok[0] && ok[1]) : (ok[0] || ok[1]);
        acc = v && exp_rdy;
        ev = 2'b00; el[0] = '0; el[1] = '0; ln = 0; pend_go = 0;
        if (pend) begin
            while (ln < 2 && !ok[ln]) ln++;
            if (ln < 2) begin
                ev[ln] = 1'b1; el[ln] = {1'b1, pend_tag, 1'b1, pend_opnd}; pend_go = 1; ln++;
            end
        end
        if (acc) begin
            while (ln < 2 && !ok[ln]) ln++;
            if (ln < 2) begin
                ev[ln] = 1'b1; el[ln] = {1'b1, t, 1'b0, d[HW-1:0]};
            end
        end
        rq = (ctx != "") ? ctx : (!st[0] && !ok[1] && st[1]) ? "R8" :
             (!ok[0] && !ok[1]) ? "R8" : (pend && !dm) ? "R4" : pend ? "R5" : "R8";
        chk(rq, "in_ready", {31'b0, in_ready}, {31'b0, exp_rdy});
        al[0] = lane0_vld ? {1'b1, lane0_tag, lane0_half, lane0_opnd} : 24'h0;
        al[1] = lane1_vld ? {1'b1, lane1_tag, lane1_half, lane1_opnd} : 24'h0;
        for (int k = 0; k < 2; k++) begin
            chk(lane_req(k, ev, el[k], st, dm, ctx), (k == 0) ? "lane0" : "lane1",
                {8'b0, al[k]}, {8'b0, el[k]});
        end
        @(posedge clk);
        if (acc && w) begin
            pend = 1; pend_tag = t; pend_opnd = d[2*HW-1:HW];
        end else if (pend_go) begin
            pend = 0;
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1; in_valid = 1'b0; lane_stall = 2'b00;
        repeat (n) @(posedge clk);
        pend = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        int seed;
        bit dm;
        seed = $urandom(32'h5eed);
        @(negedge clk);
        do_reset(3);
        // R9: idle after reset, ready high, no lane active
        step(0, 0, 6'h00, 32'h0, 2'b00, 1, "R9");
        // R1: lone half-width op
        step(1, 0, 6'h11, 32'hAAAA_1234, 2'b00, 1, "");
        // R3, R6: chained full-width ops in paired mode, then a half-width op
        step(1, 1, 6'h21, 32'hB1B1_C1C1, 2'b00, 1, "");
        step(1, 1, 6'h22, 32'hB2B2_C2C2, 2'b00, 1, "");
        step(1, 0, 6'h23, 32'h0000_D3D3, 2'b00, 1, "");
        step(0, 0, 6'h00, 32'h0, 2'b00, 1, "");
        // R4: sequential mode, halves back to back, next op waits
        step(1, 1, 6'h31, 32'hE1E1_F1F1, 2'b00, 0, "");
        step(1, 0, 6'h32, 32'h0000_F2F2, 2'b00, 0, "");
        step(1, 0, 6'h32, 32'h0000_F2F2, 2'b00, 0, "");
        // R7: lane 0 stalled in paired mode, everything on lane 1
        step(1, 1, 6'h41, 32'h4141_4242, 2'b01, 1, "");
        step(1, 0, 6'h42, 32'h0000_4343, 2'b01, 1, "");
        step(1, 0, 6'h42, 32'h0000_4343, 2'b01, 1, "");
        // R8: full-width op then all lanes blocked
        step(1, 1, 6'h51, 32'h5151_5252, 2'b00, 1, "");
        step(1, 0, 6'h52, 32'h0000_5353, 2'b11, 1, "");
        step(1, 0, 6'h52, 32'h0000_5353, 2'b01, 0, "");
        step(1, 0, 6'h52, 32'h0000_5353, 2'b00, 1, "");
        // R9: reset while an upper half is held
        step(1, 1, 6'h61, 32'h6161_6262, 2'b00, 0, "");
        do_reset(1);
        step(0, 0, 6'h00, 32'h0, 2'b00, 0, "R9");
        step(0, 0, 6'h00, 32'h0, 2'b00, 1, "R9");
        // R10: seeded random mix of widths, gaps, stalls and modes
        dm = 1;
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 48 == 0) dm = ~dm;
            step(($urandom % 4) != 0, $urandom % 2, TW'($urandom), $urandom,
                 {($urandom % 6) == 0, ($urandom % 6) == 0}, dm, "R10");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule